// File: doc/BRIEF.md
# Variable-Length SPI Master Shifter

This block is a serial peripheral interface master whose transfers are not tied to byte sizes. The host hands it a frame as a series of chunks. Each chunk carries up to 16 data bits, its own bit count and a flag that marks it as the final chunk of the frame. All chunks of a frame are shifted out under one chip-select assertion, one directly after another, with no padding bits and no realignment. A device that wants 3 bits, then 2, then 4, then 2 can be fed those fields exactly as the host computes them.

Clock polarity and phase are selectable, so all four standard modes are available. The host also sets a divider that stretches every half period of the serial clock. A centered mode gives each bit three equal intervals: data setup with the clock idle, the clock pulse, and data hold with the clock idle again. Each clock pulse therefore sits in the middle of a stable data window. This suits links that carry RC filtering and need long settling times. The bits received on the serial input are returned right-aligned with a one-cycle completion pulse for every chunk.

Top module: `varlen_spi_master`

## Requirements
- R1: In standard mode (`cfg_center`=0), with `cfg_cpol` giving the idle level of `sck` and `cfg_cpha`=0 or 1 giving the phase, `mosi` changes on one `sck` edge and `miso` is sampled on the opposite edge. A slave that follows the same mode receives every transmitted bit correctly in all four combinations.
- R2: One half period of `sck` lasts `cfg_div`+2 system clock cycles. In standard mode, leading edges within a chunk are 2·(`cfg_div`+2) cycles apart, so the fastest serial clock period is 4 cycles. In every mode the active clock pulse lasts exactly one half period.
- R3: `cfg_div`, `cfg_cpol`, `cfg_cpha` and `cfg_center` are captured when the first chunk of a frame is accepted. Changes to them before chip select releases have no effect on the frame's timing.
- R4: A chunk of length `chunk_len` (1 to 16) sends only bits `chunk_len`-1 down to 0 of `chunk_data`, most significant bit first. Higher bits of `chunk_data` are ignored.
- R5: The chunks of a frame are sent in order under one chip-select assertion, with no extra bits between them. This gives any total length, for example 9, 11 or 26 bits.
- R6: `cs_n` goes low when the first chunk is accepted. It stays low between chunks and goes high one half period after the end of the last bit of a chunk flagged `chunk_last`. The first leading `sck` edge follows `cs_n` falling by one half period with phase 1 in standard mode, and by two half periods otherwise.
- R7: A chunk is taken only on a cycle where `start` and `ready` are both high. While the block waits for the next chunk of a frame, `sck` rests at its idle level.
- R8: In centered mode, each bit spends one half period with `sck` idle and the new data on `mosi`, then one half period with `sck` active, then one half period idle with the same data. Leading edges within a chunk are therefore three half periods apart.
- R9: `miso` is sampled once per bit: in standard mode on the sampling edge, in centered mode at the middle of the clock pulse. For every chunk, `done` is high for exactly one cycle after its last bit. During that cycle `rx_data` holds that chunk's received bits right-aligned, first received bit highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | Clock phase in standard mode |
| cfg_center | input | 1 | 1 selects centered-pulse timing |
| cfg_div | input | DIV_W | Half period is this value plus 2 cycles |
| start | input | 1 | Host offers a chunk |
| chunk_data | input | DATA_W | Chunk bits, right-aligned |
| chunk_len | input | LEN_W | Number of bits in the chunk, 1..DATA_W |
| chunk_last | input | 1 | Chunk closes the frame |
| ready | output | 1 | Block can accept a chunk |
| done | output | 1 | One-cycle pulse at the end of each chunk |
| rx_data | output | DATA_W | Received chunk bits, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The completion pulse of one chunk and the acceptance of the next can occur in the same cycle, because `ready` rises together with `done`. The bench provokes this by offering the next chunk with no gap at all on some chunk boundaries and with a few idle cycles on others. On every such boundary it judges that `rx_data` still holds the finished chunk and that the slave model's captured bit stream has no gap and no duplicated bit. It also judges that `sck` stayed idle across the boundary. The divider input is also changed during each frame, right after the first chunk is accepted, to show that the frame's edge spacing does not follow it.

// File: rtl/varlen_spi_master.sv
module varlen_spi_master #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W + 1),
  localparam int CNT_W = DIV_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_center,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              start,
  input  logic [DATA_W-1:0] chunk_data,
  input  logic [LEN_W-1:0]  chunk_len,
  input  logic              chunk_last,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_BIT, S_WAIT, S_TAIL} st_t;

  st_t               state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        seg;
  logic [LEN_W-1:0]  bits_left;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_out;
  logic [DIV_W-1:0]  div_q;
  logic              cpol_q, cpha_q, ctr_q, last_q, done_r;

  logic [CNT_W-1:0]  hl, mid;
  logic              accept, seg_end, last_seg, samp;

  assign hl       = (state == S_IDLE ? {1'b0, cfg_div} : {1'b0, div_q}) + CNT_W'(2);
  assign mid      = hl - (hl >> 1);
  assign ready    = (state == S_IDLE) || (state == S_WAIT);
  assign accept   = start && ready;
  assign seg_end  = (cnt == '0);
  assign last_seg = ctr_q ? (seg == 2'd2) : (seg == 2'd1);
  assign samp     = (state == S_BIT) &&
                    (ctr_q ? (seg == 2'd1 && cnt == mid) : (seg == 2'd0 && seg_end));

  always_comb begin
    sck = cpol_q;
    if (state == S_BIT)
      sck = ctr_q ? (cpol_q ^ (seg == 2'd1)) : (cpol_q ^ seg[0] ^ cpha_q);
  end

  assign mosi    = tx_sh[DATA_W-1];
  assign cs_n    = (state == S_IDLE);
  assign done    = done_r;
  assign rx_data = rx_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      seg       <= '0;
      bits_left <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_out    <= '0;
      div_q     <= '0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      ctr_q     <= 1'b0;
      last_q    <= 1'b0;
      done_r    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (samp) rx_sh <= {rx_sh[DATA_W-2:0], miso};
      if (accept) begin
        tx_sh     <= chunk_data << (LEN_W'(DATA_W) - chunk_len);
        bits_left <= chunk_len;
        last_q    <= chunk_last;
        rx_sh     <= '0;
      end
      case (state)
        S_IDLE: begin
          cpol_q <= cfg_cpol;
          cpha_q <= cfg_cpha;
          ctr_q  <= cfg_center;
          div_q  <= cfg_div;
          if (accept) begin
            state <= S_LEAD;
            cnt   <= hl - CNT_W'(1);
          end
        end
        S_LEAD: begin
          if (seg_end) begin
            state <= S_BIT;
            seg   <= '0;
            cnt   <= hl - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_BIT: begin
          if (seg_end) begin
            cnt <= hl - CNT_W'(1);
            if (last_seg) begin
              seg       <= '0;
              tx_sh     <= {tx_sh[DATA_W-2:0], 1'b0};
              bits_left <= bits_left - LEN_W'(1);
              if (bits_left == LEN_W'(1)) begin
                done_r <= 1'b1;
                rx_out <= rx_sh;
                state  <= last_q ? S_TAIL : S_WAIT;
              end
            end else begin
              seg <= seg + 2'd1;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_WAIT: begin
          if (accept) begin
            state <= S_BIT;
            seg   <= '0;
            cnt   <= hl - CNT_W'(1);
          end
        end
        S_TAIL: begin
          if (seg_end) state <= S_IDLE;
          else         cnt   <= cnt - CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(div_q));

  a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (chunk_len != '0 && chunk_len <= LEN_W'(DATA_W)));

  a_r7_wait_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !cs_n) |-> (sck == cpol_q));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(state) == S_TAIL));

  a_r5_cs_held_between: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cs_n) |=> (!cs_n || $past(last_q)));

endmodule

// File: tb/sim_varlen_spi_master.sv
module sim_varlen_spi_master;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_center = 0;
  logic [7:0] cfg_div = 0;
  logic start = 0, chunk_last = 0;
  logic [15:0] chunk_data = 0;
  logic [4:0] chunk_len = 1;
  logic ready, done, sck, mosi, miso, cs_n;
  logic [15:0] rx_data;

  always #(CLK_P/2) clk = ~clk;

  varlen_spi_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_center(cfg_center), .cfg_div(cfg_div), .start(start),
    .chunk_data(chunk_data), .chunk_len(chunk_len), .chunk_last(chunk_last),
    .ready(ready), .done(done), .rx_data(rx_data), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  int nchk = 0, nfail = 0;
  int ch_len [8];
  logic [15:0] ch_dat [8];
  logic [63:0] miso_pat = 0, cap_bits = 0, exp_bits = 0;
  int cap_n = 0, exp_n = 0, sidx = 0;
  bit cp_b = 0, cph_b = 0, cen_b = 0;
  int rx_pos = 0, done_idx = 0;

  int cyc = 0, t_cs = 0, first_lead = -1, last_lead = -1, last_edge = 0, t_l = 0;
  int min_gap = 1000000, minw = 1000000, maxw = 0, tail = 0;
  logic prev_sck = 0, prev_csn = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  assign miso = (sidx >= 0 && sidx < 64) ? miso_pat[63 - sidx] : 1'b0;

  always @(negedge cs_n) begin
    if (rst_n) begin
      sidx = (cph_b && !cen_b) ? -1 : 0;
      cap_bits = 0;
      cap_n = 0;
    end
  end

  always @(sck) begin
    if (rst_n && !cs_n) begin
      if (sck != cp_b) begin
        if (cph_b && !cen_b) sidx = sidx + 1;
        else begin cap_bits = {cap_bits[62:0], mosi}; cap_n++; end
      end else begin
        if (cph_b && !cen_b) begin cap_bits = {cap_bits[62:0], mosi}; cap_n++; end
        else sidx = sidx + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_csn && !cs_n) begin
        t_cs = cyc; first_lead = -1; last_lead = -1;
        min_gap = 1000000; minw = 1000000; maxw = 0;
      end
      if (!cs_n && sck != prev_sck) begin
        last_edge = cyc;
        if (sck != cp_b) begin
          if (first_lead < 0) first_lead = cyc - t_cs;
          else if (cyc - last_lead < min_gap) min_gap = cyc - last_lead;
          last_lead = cyc;
          t_l = cyc;
        end else begin
          if (cyc - t_l < minw) minw = cyc - t_l;
          if (cyc - t_l > maxw) maxw = cyc - t_l;
        end
      end
      if (!prev_csn && cs_n) tail = cyc - last_edge;
      if (done) begin
        logic [15:0] ev;
        ev = 0;
        for (int k = 0; k < ch_len[done_idx]; k++)
          ev = {ev[14:0], miso_pat[63 - (rx_pos + k)]};
        chk(rx_data == ev, "R9", "rx_data at done", 64'(rx_data), 64'(ev));
        rx_pos += ch_len[done_idx];
        done_idx++;
      end
    end
    prev_sck = sck;
    prev_csn = cs_n;
  end

  task automatic do_frame(input int nch, input bit cp, input bit cph,
                          input bit cen, input int dv);
    int h;
    cfg_cpol = cp; cfg_cpha = cph; cfg_center = cen; cfg_div = 8'(dv);
    cp_b = cp; cph_b = cph; cen_b = cen;
    h = dv + 2;
    repeat (3) @(negedge clk);
    miso_pat = {$urandom, $urandom};
    exp_bits = 0; exp_n = 0; rx_pos = 0; done_idx = 0;
    for (int i = 0; i < nch; i++)
      for (int b = ch_len[i] - 1; b >= 0; b--) begin
        exp_bits = {exp_bits[62:0], ch_dat[i][b]};
        exp_n++;
      end
    for (int i = 0; i < nch; i++) begin
      while (!ready) @(negedge clk);
      if (i > 0) begin
        int gap;
        gap = $urandom % 4;
        chk(sck == cp, "R7", "sck idle between chunks", 64'(sck), 64'(cp));
        repeat (gap) @(negedge clk);
        if (gap > 0)
          chk(sck == cp && ready && !cs_n, "R7", "sck idle while waiting", 64'(sck), 64'(cp));
      end
      start = 1; chunk_data = ch_dat[i]; chunk_len = 5'(ch_len[i]);
      chunk_last = (i == nch - 1);
      @(negedge clk);
      start = 0;
      if (i == 0) begin
        cfg_div = 8'($urandom % 4 + 1 + dv);
        cfg_cpol = ~cp;
      end
    end
    while (!cs_n) @(negedge clk);
    @(negedge clk);
    chk(cap_n == exp_n, "R5", "bit count under one CS", 64'(cap_n), 64'(exp_n));
    chk(cap_bits == exp_bits, "R1 R4", "bit stream seen by slave", cap_bits, exp_bits);
    chk(done_idx == nch, "R9", "done pulses per frame", 64'(done_idx), 64'(nch));
    chk(first_lead == ((cph && !cen) ? h : 2*h), "R6", "CS to first edge",
        64'(first_lead), 64'((cph && !cen) ? h : 2*h));
    chk(tail == ((cph || cen) ? 2*h : h), "R6", "last edge to CS release",
        64'(tail), 64'((cph || cen) ? 2*h : h));
    if (exp_n >= 2)
      chk(min_gap == (cen ? 3*h : 2*h), cen ? "R8 R3" : "R2 R3", "leading edge spacing",
          64'(min_gap), 64'(cen ? 3*h : 2*h));
    chk(minw == h && maxw == h, cen ? "R8" : "R2", "pulse width", 64'(maxw), 64'(h));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R6", "reset cs_n", 64'(cs_n), 64'd1);
    chk(ready == 1'b1 && done == 1'b0, "R7", "reset ready/done", 64'({ready, done}), 64'b10);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(sck == cfg_cpol, "R7", "idle sck level", 64'(sck), 64'(cfg_cpol));

    ch_len[0] = 3; ch_dat[0] = 16'hFFF6;
    ch_len[1] = 2; ch_dat[1] = 16'h0002;
    ch_len[2] = 4; ch_dat[2] = 16'hA00D;
    ch_len[3] = 2; ch_dat[3] = 16'h0001;
    do_frame(4, 0, 0, 0, 0);
    ch_len[0] = 9; ch_dat[0] = 16'h0155;
    do_frame(1, 1, 0, 0, 1);
    ch_len[0] = 16; ch_dat[0] = 16'hC3A5;
    ch_len[1] = 10; ch_dat[1] = 16'hFE5A;
    do_frame(2, 1, 1, 0, 0);
    ch_len[0] = 1; ch_dat[0] = 16'hFFFF;
    do_frame(1, 0, 1, 1, 0);
    ch_len[0] = 16; ch_dat[0] = 16'hFFFF;
    ch_len[1] = 11; ch_dat[1] = 16'h0000;
    do_frame(2, 0, 1, 0, 2);
    ch_len[0] = 16; ch_dat[0] = 16'h8001;
    do_frame(1, 1, 0, 1, 3);

    for (int f = 0; f < 32; f++) begin
      int n;
      n = 1 + $urandom % 4;
      for (int i = 0; i < n; i++) begin
        ch_len[i] = 1 + $urandom % 16;
        ch_dat[i] = 16'($urandom);
      end
      do_frame(n, 1'($urandom), 1'($urandom), 1'($urandom), $urandom % 4);
    end
    finish_up();
  end
endmodule